// File: doc/BRIEF.md
# Double-and-Add Scalar Multiply Sequencer

This block sequences the multiplication of a fixed base point G by a scalar k. It keeps a running point R in Jacobian coordinates (X, Y, Z) and walks the scalar one bit at a time, starting at the most significant bit. On every bit it asks an external doubling engine for T = 2R, and then asks an external addition engine for T + G. It keeps the sum when the bit is one and keeps T when the bit is zero. The addition is requested on every bit, whatever the bit value is.

After the last bit, the sequencer asks an inversion service for Z⁻² and Z⁻³. It then uses a modular multiplier twice, to form the affine X = X·Z⁻² and the affine Y = Y·Z⁻³. If the final Z is zero, R is the point at infinity, and both affine outputs are forced to zero. All arithmetic lives outside this block. Each engine is reached through a level request that is held until a one-cycle acknowledge returns the result.

The scalar is split into `WORDS` words of `WORD_W` bits each. The number of iterations is `WORDS*WORD_W`. Word `w` occupies scalar bits `[w*WORD_W +: WORD_W]`.

Top module: `scm_ctrl`

## Requirements
- R1: After reset, all four requests are low, `done` is low, and `qx` and `qy` are zero.
- R2: At `start`, R is set to the point at infinity, coded X=1, Y=1, Z=0. The first doubling request of a run carries (1, 1, 0).
- R3: Each iteration issues a doubling request first. The following addition request carries exactly the coordinates that the doubling engine returned.
- R4: Scalar bits are used from the highest word to the lowest word, and from the most significant bit to the least significant bit within a word. A one bit keeps the sum, and a zero bit keeps the doubled point. The addition is requested on every iteration.
- R5: A request stays high, with its operands unchanged, until its acknowledge arrives. At most one request is high at a time.
- R6: After the last iteration, an inversion request carries the final Z. Then one multiply request is issued with operands (X, Z⁻²), followed by one with operands (Y, Z⁻³).
- R7: When the final Z is zero, `qx` and `qy` are both written as zero.
- R8: `done` is a one-cycle pulse. It rises the cycle after the Y multiply is acknowledged. `qx` and `qy` keep their values until the next run overwrites them.
- R9: The scalar is captured at `start`. A `start` pulse or a change of `scalar` during a run has no effect on that run, and starts no second run.
- R10: A run issues exactly `WORDS*WORD_W` doubling requests and the same number of addition requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| scalar | input | WORDS*WORD_W | Scalar k |
| dbl_req | output | 1 | Doubling request |
| dbl_px | output | CW | Doubling operand X |
| dbl_py | output | CW | Doubling operand Y |
| dbl_pz | output | CW | Doubling operand Z |
| dbl_ack | input | 1 | Doubling result valid |
| dbl_rx | input | CW | Doubled X |
| dbl_ry | input | CW | Doubled Y |
| dbl_rz | input | CW | Doubled Z |
| add_req | output | 1 | Addition request (adds G) |
| add_px | output | CW | Addition operand X |
| add_py | output | CW | Addition operand Y |
| add_pz | output | CW | Addition operand Z |
| add_ack | input | 1 | Sum valid |
| add_rx | input | CW | Sum X |
| add_ry | input | CW | Sum Y |
| add_rz | input | CW | Sum Z |
| inv_req | output | 1 | Inversion request |
| inv_z | output | CW | Value to invert |
| inv_ack | input | 1 | Inverse powers valid |
| inv_z2 | input | CW | Z to the power -2 |
| inv_z3 | input | CW | Z to the power -3 |
| mul_req | output | 1 | Multiply request |
| mul_a | output | CW | Multiplicand |
| mul_b | output | CW | Multiplier |
| mul_ack | input | 1 | Product valid |
| mul_p | input | CW | Product |
| qx | output | CW | Affine X result |
| qy | output | CW | Affine Y result |
| done | output | 1 | One-cycle completion pulse |

## Verification
A request becomes visible at the ports one clock edge after the state that owns it is entered. An acknowledged result is captured at the edge where the acknowledge is sampled, so the next request appears one cycle after the acknowledge. `qx` is written at the edge that samples the X multiply acknowledge, and `qy` at the edge that samples the Y multiply acknowledge. `done` is high for the one cycle after that. The bench drives acknowledges and samples every output at the falling edge. It compares `qx` and `qy` in the cycle where `done` is high, and checks the next falling edge for the end of the pulse and for the held results.

// File: rtl/scm_pkg.sv
package scm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DBL,
        S_ADD,
        S_INV,
        S_MULX,
        S_MULY,
        S_FIN
    } scm_state_e;

endpackage

// File: rtl/scm_bit_pick.sv
module scm_bit_pick #(
    parameter int WORDS  = 2,
    parameter int WORD_W = 4,
    parameter int WSW    = 1,
    parameter int BSW    = 2
) (
    input  logic [WORDS*WORD_W-1:0] k,
    input  logic [WSW-1:0]          wsel,
    input  logic [BSW-1:0]          bsel,
    output logic                    bit_o
);

    logic [WORD_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = k[g*WORD_W +: WORD_W];
    end

    always_comb begin
        bit_o = words[wsel][bsel];
    end

endmodule

// File: rtl/scm_point_sel.sv
module scm_point_sel #(
    parameter int CW = 16
) (
    input  logic          keep_sum,
    input  logic [CW-1:0] sx,
    input  logic [CW-1:0] sy,
    input  logic [CW-1:0] sz,
    input  logic [CW-1:0] tx,
    input  logic [CW-1:0] ty,
    input  logic [CW-1:0] tz,
    output logic [CW-1:0] ox,
    output logic [CW-1:0] oy,
    output logic [CW-1:0] oz
);

    always_comb begin
        if (keep_sum) begin
            ox = sx;
            oy = sy;
            oz = sz;
        end else begin
            ox = tx;
            oy = ty;
            oz = tz;
        end
    end

endmodule

// File: rtl/scm_ctrl.sv
module scm_ctrl
    import scm_pkg::*;
#(
    parameter int CW     = 16,
    parameter int WORDS  = 2,
    parameter int WORD_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [WORDS*WORD_W-1:0] scalar,
    output logic                    dbl_req,
    output logic [CW-1:0]           dbl_px,
    output logic [CW-1:0]           dbl_py,
    output logic [CW-1:0]           dbl_pz,
    input  logic                    dbl_ack,
    input  logic [CW-1:0]           dbl_rx,
    input  logic [CW-1:0]           dbl_ry,
    input  logic [CW-1:0]           dbl_rz,
    output logic                    add_req,
    output logic [CW-1:0]           add_px,
    output logic [CW-1:0]           add_py,
    output logic [CW-1:0]           add_pz,
    input  logic                    add_ack,
    input  logic [CW-1:0]           add_rx,
    input  logic [CW-1:0]           add_ry,
    input  logic [CW-1:0]           add_rz,
    output logic                    inv_req,
    output logic [CW-1:0]           inv_z,
    input  logic                    inv_ack,
    input  logic [CW-1:0]           inv_z2,
    input  logic [CW-1:0]           inv_z3,
    output logic                    mul_req,
    output logic [CW-1:0]           mul_a,
    output logic [CW-1:0]           mul_b,
    input  logic                    mul_ack,
    input  logic [CW-1:0]           mul_p,
    output logic [CW-1:0]           qx,
    output logic [CW-1:0]           qy,
    output logic                    done
);

    localparam int KW  = WORDS * WORD_W;
    localparam int WSW = (WORDS  > 1) ? $clog2(WORDS)  : 1;
    localparam int BSW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    typedef struct packed {
        scm_state_e     st;
        logic [WSW-1:0] wsel;
        logic [BSW-1:0] bsel;
        logic [KW-1:0]  k;
        logic [CW-1:0]  rx;
        logic [CW-1:0]  ry;
        logic [CW-1:0]  rz;
        logic [CW-1:0]  tx;
        logic [CW-1:0]  ty;
        logic [CW-1:0]  tz;
        logic [CW-1:0]  z2;
        logic [CW-1:0]  z3;
        logic           inf;
        logic [CW-1:0]  qx;
        logic [CW-1:0]  qy;
    } regs_t;

    regs_t q, d;

    logic          cur_bit;
    logic          last_iter;
    logic [CW-1:0] nx, ny, nz;

    scm_bit_pick #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W),
        .WSW    (WSW),
        .BSW    (BSW)
    ) u_pick (
        .k     (q.k),
        .wsel  (q.wsel),
        .bsel  (q.bsel),
        .bit_o (cur_bit)
    );

    scm_point_sel #(
        .CW (CW)
    ) u_sel (
        .keep_sum (cur_bit),
        .sx       (add_rx),
        .sy       (add_ry),
        .sz       (add_rz),
        .tx       (q.tx),
        .ty       (q.ty),
        .tz       (q.tz),
        .ox       (nx),
        .oy       (ny),
        .oz       (nz)
    );

    assign last_iter = (q.wsel == '0) && (q.bsel == '0);

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.k    = scalar;
                    d.rx   = CW'(1);
                    d.ry   = CW'(1);
                    d.rz   = '0;
                    d.wsel = WSW'(WORDS - 1);
                    d.bsel = BSW'(WORD_W - 1);
                    d.st   = S_DBL;
                end
            end
            S_DBL: begin
                if (dbl_ack) begin
                    d.tx = dbl_rx;
                    d.ty = dbl_ry;
                    d.tz = dbl_rz;
                    d.st = S_ADD;
                end
            end
            S_ADD: begin
                if (add_ack) begin
                    d.rx = nx;
                    d.ry = ny;
                    d.rz = nz;
                    if (last_iter) begin
                        d.st = S_INV;
                    end else begin
                        if (q.bsel == '0) begin
                            d.bsel = BSW'(WORD_W - 1);
                            d.wsel = q.wsel - WSW'(1);
                        end else begin
                            d.bsel = q.bsel - BSW'(1);
                        end
                        d.st = S_DBL;
                    end
                end
            end
            S_INV: begin
                if (inv_ack) begin
                    d.z2  = inv_z2;
                    d.z3  = inv_z3;
                    d.inf = (q.rz == '0);
                    d.st  = S_MULX;
                end
            end
            S_MULX: begin
                if (mul_ack) begin
                    d.qx = q.inf ? '0 : mul_p;
                    d.st = S_MULY;
                end
            end
            S_MULY: begin
                if (mul_ack) begin
                    d.qy = q.inf ? '0 : mul_p;
                    d.st = S_FIN;
                end
            end
            S_FIN: begin
                d.st = S_IDLE;
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dbl_req = (q.st == S_DBL);
    assign dbl_px  = q.rx;
    assign dbl_py  = q.ry;
    assign dbl_pz  = q.rz;
    assign add_req = (q.st == S_ADD);
    assign add_px  = q.tx;
    assign add_py  = q.ty;
    assign add_pz  = q.tz;
    assign inv_req = (q.st == S_INV);
    assign inv_z   = q.rz;
    assign mul_req = (q.st == S_MULX) || (q.st == S_MULY);
    assign mul_a   = (q.st == S_MULY) ? q.ry : q.rx;
    assign mul_b   = (q.st == S_MULY) ? q.z3 : q.z2;
    assign qx      = q.qx;
    assign qy      = q.qy;
    assign done    = (q.st == S_FIN);

endmodule

// File: rtl/scm_ctrl_chk.sv
module scm_ctrl_chk #(
    parameter int CW     = 16,
    parameter int WORDS  = 2,
    parameter int WORD_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [WORDS*WORD_W-1:0] scalar,
    input logic                    dbl_req,
    input logic [CW-1:0]           dbl_px,
    input logic [CW-1:0]           dbl_py,
    input logic [CW-1:0]           dbl_pz,
    input logic                    dbl_ack,
    input logic [CW-1:0]           dbl_rx,
    input logic [CW-1:0]           dbl_ry,
    input logic [CW-1:0]           dbl_rz,
    input logic                    add_req,
    input logic [CW-1:0]           add_px,
    input logic [CW-1:0]           add_py,
    input logic [CW-1:0]           add_pz,
    input logic                    add_ack,
    input logic [CW-1:0]           add_rx,
    input logic [CW-1:0]           add_ry,
    input logic [CW-1:0]           add_rz,
    input logic                    inv_req,
    input logic [CW-1:0]           inv_z,
    input logic                    inv_ack,
    input logic [CW-1:0]           inv_z2,
    input logic [CW-1:0]           inv_z3,
    input logic                    mul_req,
    input logic [CW-1:0]           mul_a,
    input logic [CW-1:0]           mul_b,
    input logic                    mul_ack,
    input logic [CW-1:0]           mul_p,
    input logic [CW-1:0]           qx,
    input logic [CW-1:0]           qy,
    input logic                    done
);

    a_r5_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dbl_req, add_req, inv_req, mul_req}));

    a_r5_dbl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_req && !dbl_ack) |=> (dbl_req && $stable(dbl_px) && $stable(dbl_py) && $stable(dbl_pz)));

    a_r5_add_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (add_req && !add_ack) |=> (add_req && $stable(add_px) && $stable(add_py) && $stable(add_pz)));

    a_r5_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !inv_ack) |=> (inv_req && $stable(inv_z)));

    a_r5_mul_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_req && !mul_ack) |=> (mul_req && $stable(mul_a) && $stable(mul_b)));

    a_r3_add_after_dbl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(add_req) |-> $past(dbl_ack));

    a_r3_add_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_req && dbl_ack) |=> (add_px == $past(dbl_rx) && add_py == $past(dbl_ry) && add_pz == $past(dbl_rz)));

    a_r6_inv_after_add: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_req) |-> $past(add_ack));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_mul: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mul_ack));

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mul_ack) |=> ($stable(qx) && $stable(qy)));

endmodule

bind scm_ctrl scm_ctrl_chk #(
    .CW     (CW),
    .WORDS  (WORDS),
    .WORD_W (WORD_W)
) u_chk (.*);

// File: tb/tb_scm_ctrl.sv
module tb_scm_ctrl;

    localparam int CW     = 16;
    localparam int WORDS  = 2;
    localparam int WORD_W = 4;
    localparam int KW     = WORDS * WORD_W;
    localparam int NVEC   = 6;

    // each entry: scalar in [15:8], engine latency in [7:0]
    localparam logic [15:0] VEC [NVEC] = '{
        16'h00_01, 16'h01_00, 16'h80_02, 16'hFF_01, 16'hA5_03, 16'h3C_00
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [KW-1:0] scalar = '0;
    logic          dbl_req, add_req, inv_req, mul_req, done;
    logic [CW-1:0] dbl_px, dbl_py, dbl_pz, add_px, add_py, add_pz;
    logic [CW-1:0] inv_z, mul_a, mul_b, qx, qy;
    logic          dbl_ack = 1'b0, add_ack = 1'b0, inv_ack = 1'b0, mul_ack = 1'b0;
    logic [CW-1:0] dbl_rx = '0, dbl_ry = '0, dbl_rz = '0;
    logic [CW-1:0] add_rx = '0, add_ry = '0, add_rz = '0;
    logic [CW-1:0] inv_z2 = '0, inv_z3 = '0, mul_p = '0;

    int n_run = 0;
    int n_fail = 0;
    int lat = 0;
    int n_dbl = 0;
    int n_add = 0;
    int n_done = 0;
    bit first_dbl = 1'b0;
    logic [CW-1:0] last_tx, last_ty, last_tz, exp_z;

    always #10 clk = ~clk;

    scm_ctrl #(.CW(CW), .WORDS(WORDS), .WORD_W(WORD_W)) dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bench-side engine models (arbitrary deterministic arithmetic)
    function automatic logic [3*CW-1:0] f_dbl(input logic [CW-1:0] x, y, z);
        return {CW'(x * 3 + 1), CW'(y + x), CW'(z << 1)};
    endfunction

    function automatic logic [3*CW-1:0] f_add(input logic [CW-1:0] x, y, z);
        return {CW'(x + 16'h1234), y ^ 16'h00FF, CW'(z + 1)};
    endfunction

    task automatic ref_run(input logic [KW-1:0] k, output logic [CW-1:0] ex, ey, ez);
        logic [CW-1:0] x, y, z, tx, ty, tz;
        x = 1; y = 1; z = 0;
        for (int i = KW - 1; i >= 0; i--) begin
            {tx, ty, tz} = f_dbl(x, y, z);
            if (k[i]) {x, y, z} = f_add(tx, ty, tz);
            else {x, y, z} = {tx, ty, tz};
        end
        ez = z;
        if (z == 0) begin
            ex = 0; ey = 0;
        end else begin
            ex = CW'(x * (z ^ 16'hAAAA));
            ey = CW'(y * CW'(z + 16'h0101));
        end
    endtask

    initial begin : dbl_engine
        logic [CW-1:0] cx, cy, cz;
        forever begin
            @(negedge clk);
            if (dbl_req === 1'b1) begin
                cx = dbl_px; cy = dbl_py; cz = dbl_pz;
                if (first_dbl) begin
                    chk(cx == 1 && cy == 1 && cz == 0, "R2 first doubling operand", {cx[7:0], cy[7:0], cz}, 32'h0101_0000);
                    first_dbl = 1'b0;
                end
                n_dbl++;
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    chk(dbl_req && dbl_px == cx && dbl_py == cy && dbl_pz == cz, "R5 doubling request held", dbl_px, cx);
                end
                {dbl_rx, dbl_ry, dbl_rz} = f_dbl(cx, cy, cz);
                {last_tx, last_ty, last_tz} = {dbl_rx, dbl_ry, dbl_rz};
                dbl_ack = 1'b1;
                @(negedge clk);
                dbl_ack = 1'b0;
            end
        end
    end

    initial begin : add_engine
        logic [CW-1:0] cx, cy, cz;
        forever begin
            @(negedge clk);
            if (add_req === 1'b1) begin
                cx = add_px; cy = add_py; cz = add_pz;
                chk(cx == last_tx && cy == last_ty && cz == last_tz, "R3 addition operand is doubled point", cx, last_tx);
                n_add++;
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    chk(add_req && add_px == cx && add_py == cy && add_pz == cz, "R5 addition request held", add_px, cx);
                end
                {add_rx, add_ry, add_rz} = f_add(cx, cy, cz);
                add_ack = 1'b1;
                @(negedge clk);
                add_ack = 1'b0;
            end
        end
    end

    initial begin : inv_engine
        logic [CW-1:0] cz;
        forever begin
            @(negedge clk);
            if (inv_req === 1'b1) begin
                cz = inv_z;
                chk(cz == exp_z, "R6 inversion operand is final Z", cz, exp_z);
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    chk(inv_req && inv_z == cz, "R5 inversion request held", inv_z, cz);
                end
                inv_z2 = cz ^ 16'hAAAA;
                inv_z3 = CW'(cz + 16'h0101);
                inv_ack = 1'b1;
                @(negedge clk);
                inv_ack = 1'b0;
            end
        end
    end

    initial begin : mul_engine
        logic [CW-1:0] ca, cb;
        forever begin
            @(negedge clk);
            if (mul_req === 1'b1) begin
                ca = mul_a; cb = mul_b;
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    chk(mul_req && mul_a == ca && mul_b == cb, "R5 multiply request held", mul_a, ca);
                end
                mul_p = CW'(ca * cb);
                mul_ack = 1'b1;
                @(negedge clk);
                mul_ack = 1'b0;
            end
        end
    end

    initial begin : done_count
        forever begin
            @(negedge clk);
            if (done === 1'b1) n_done++;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic wait_done();
        int guard;
        guard = 0;
        while (done !== 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done === 1'b1, "R8 done observed", 32'(done), 1);
    endtask

    task automatic run_case(input logic [KW-1:0] k, input int l);
        logic [CW-1:0] ex, ey;
        lat = l;
        ref_run(k, ex, ey, exp_z);
        first_dbl = 1'b1;
        n_dbl = 0;
        n_add = 0;
        @(negedge clk);
        scalar = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        if (exp_z == 0) begin
            chk(qx == 0 && qy == 0, "R7 infinite result gives zero outputs", {qx, qy}, 0);
        end else begin
            chk(qx == ex, "R4 affine X", qx, ex);
            chk(qy == ey, "R4 affine Y", qy, ey);
        end
        chk(n_dbl == KW, "R10 doubling count", n_dbl, KW);
        chk(n_add == KW, "R4 addition requested every bit", n_add, KW);
        @(negedge clk);
        chk(done == 1'b0, "R8 done lasts one cycle", 32'(done), 0);
        repeat (3) @(negedge clk);
        chk(qx == ex && qy == ey, "R8 results held after done", {qx, qy}, {ex, ey});
    endtask

    initial begin : main
        logic [CW-1:0] ex, ey, ez;
        repeat (3) @(negedge clk);
        chk({dbl_req, add_req, inv_req, mul_req} == 0, "R1 requests low in reset", 32'({dbl_req, add_req, inv_req, mul_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({dbl_req, add_req, inv_req, mul_req} == 0, "R1 requests low after reset", 32'({dbl_req, add_req, inv_req, mul_req}), 0);
        chk(done == 1'b0, "R1 done low after reset", 32'(done), 0);
        chk(qx == 0 && qy == 0, "R1 results zero after reset", {qx, qy}, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_case(VEC[v][15:8], int'(VEC[v][7:0]));
        end

        // R9: start pulses and scalar changes during a run are ignored
        lat = 1;
        ref_run(8'h5A, ex, ey, ez);
        exp_z = ez;
        first_dbl = 1'b1;
        n_dbl = 0;
        n_add = 0;
        n_done = 0;
        @(negedge clk);
        scalar = 8'h5A;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        scalar = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scalar = 8'hC3;
        wait_done();
        chk(qx == ex, "R9 X follows scalar captured at start", qx, ex);
        chk(qy == ey, "R9 Y follows scalar captured at start", qy, ey);
        repeat (40) @(negedge clk);
        chk(n_done == 1, "R9 no second run from busy start", n_done, 1);
        chk(n_dbl == KW, "R9 no extra doubling requests", n_dbl, KW);

        // back-to-back: result of a zero scalar overwrites previous values
        run_case(8'h00, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule